// File: doc/BRIEF.md
# Power-Management Capability Register Block

This block holds the power-management capability structure of a PCI function's configuration space. The host reaches it through a simple configuration port: a dword address, four byte enables and 32-bit write data, with a registered read return. The block answers for the capabilities-pointer dword of the header. It also answers for two dwords of capability at byte offset 0x40. The first holds the capability identifier, the link to the next list item and the read-only capability word. The second holds the control/status word, the bridge extension byte and a power data byte.

The device-state field of the control/status word is the heart of the block. When the host moves the function to a deeper state, a sticky power-down flag is raised toward the local processor. When the host brings the function back to full power, a sticky restore flag is raised instead. Each flag drives an interrupt line through its own enable and is held until the local side clears it. The current state is driven out so that local logic can gate clocks or switch power; neither of those is done here.

Top module: `pm_cap_regs`

## Requirements
- R1: After reset, the power state is D0 (code 0), both interrupt outputs are low and the read data is zero.
- R2: Dword 13 reads 0x00000040. Dword 16 reads capability ID 0x01 in bits 7:0 and next pointer 0x00 in bits 15:8. Its bits 31:16 hold the capability word: spec version 3'b010 (revision 1.1) in bits 18:16, D1 support in bit 25 and D2 support in bit 26. With the defaults (D1 on, D2 off), the dword reads 0x02020001.
- R3: Dword 17 reads as follows. Bits 1:0 hold the state. Bit 3 is the no-soft-reset flag, set by default. Bits 12:9 hold the data selector. Bits 14:13 hold the data scale. Bits 23:16 hold the bridge extension byte, 0x00 by default. Bits 31:24 hold the data byte. All other bits read 0.
- R4: A write to dword 17 with byte enable 0 set loads bits 1:0 as the new state on the next clock edge, subject to R5 to R7. A write without byte enable 0 leaves the state unchanged.
- R5: A state write that names D1 or D2 while that state is not advertised in the capability word is ignored.
- R6: A state write to a higher-numbered (deeper) state sets the power-down flag. A write to D0 from any other state sets the restore flag. A write of the current state sets neither flag.
- R7: A write from a deeper state to a shallower state other than D0 (for example D3 to D1) is ignored and raises no flag.
- R8: Each flag stays set until its local clear input is pulsed, and a set in the same cycle wins over the clear. Each interrupt output equals its flag ANDed with its enable input.
- R9: A write to dword 17 with byte enable 1 set loads the data selector from bits 12:9. For selector values 0 to 7, the data byte and scale come from the parameter tables (defaults 0x32, 0x1E, 0x14, 0x0A, 0x05, 0x02, 0x03, 0x04, each with scale 2'b01). For selector values 8 to 15, both read 0.
- R10: A read returns its dword one clock after the read strobe. Addresses not listed in R2 and R3 read zero. The read data holds when no read is issued.
- R11: Writes to dwords 13 and 16 have no effect on what they read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Dword address in configuration space |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| loc_ien_down | input | 1 | Enable for the power-down interrupt |
| loc_ien_up | input | 1 | Enable for the restore interrupt |
| loc_clr_down | input | 1 | Clears the power-down flag |
| loc_clr_up | input | 1 | Clears the restore flag |
| pwr_state | output | 2 | Current device state, 0 = D0 to 3 = D3 |
| irq_down | output | 1 | Power-down interrupt to the local processor |
| irq_up | output | 1 | Restore interrupt to the local processor |

## Verification
Three kinds of result have fixed timing. A state write or a local clear changes the state and the flags at the first rising edge after the strobe. An enable change reaches the interrupt outputs in the same cycle, with no register in the path. Read data appears one edge after the read strobe. The bench drives every strobe for exactly one cycle from a falling edge and samples at the next falling edge, so each result is seen in the first cycle in which it is due. Where an input is expected to be ignored, the check samples that same cycle or rereads the register before any further write.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'd0,
    PS_D1 = 2'd1,
    PS_D2 = 2'd2,
    PS_D3 = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_DOWN = 2'd1,
    MV_UP   = 2'd2
  } move_e;

  localparam logic [7:0] PM_CAP_OFFSET = 8'h40;
  localparam logic [7:0] PM_CAP_ID     = 8'h01;
  localparam logic [7:0] PM_NEXT_PTR   = 8'h00;
  localparam logic [2:0] PM_SPEC_VER   = 3'b010;
  localparam int         CAPPTR_DW     = 13;
  localparam int         CAP_DW        = int'(PM_CAP_OFFSET) >> 2;
  localparam int         CSR_DW        = CAP_DW + 1;
  localparam int         NUM_DATA      = 8;
  localparam int         IRQ_DOWN      = 0;
  localparam int         IRQ_UP        = 1;
  localparam int         NUM_IRQ       = 2;

  // D0 and D3 are always available; D1/D2 follow the capability bits.
  function automatic logic state_supported(logic [1:0] s, logic d1, logic d2);
    case (s)
      2'd1:    return d1;
      2'd2:    return d2;
      default: return 1'b1;
    endcase
  endfunction

  // Classify a requested transition from the current state.
  function automatic move_e classify_move(logic [1:0] cur, logic [1:0] nxt);
    if (nxt == cur)       return MV_NONE;
    else if (nxt == 2'd0) return MV_UP;
    else if (nxt > cur)   return MV_DOWN;
    else                  return MV_NONE;
  endfunction

  function automatic logic [15:0] pack_pmc(logic [4:0] pme, logic d2, logic d1,
                                           logic [2:0] aux, logic dsi);
    return {pme, d2, d1, aux, dsi, 1'b0, 1'b0, PM_SPEC_VER};
  endfunction

  function automatic logic [15:0] pack_csr(logic [1:0] scale, logic [3:0] sel,
                                           logic nsr, logic [1:0] st);
    return {1'b0, scale, sel, 1'b0, 4'b0000, nsr, 1'b0, st};
  endfunction

  function automatic logic [7:0] pick_data(logic [3:0] sel, logic [8*NUM_DATA-1:0] tbl);
    if (int'(sel) < NUM_DATA) return tbl[{sel[2:0], 3'b000} +: 8];
    else                      return 8'h00;
  endfunction

  function automatic logic [1:0] pick_scale(logic [3:0] sel, logic [2*NUM_DATA-1:0] tbl);
    if (int'(sel) < NUM_DATA) return tbl[{sel[2:0], 1'b0} +: 2];
    else                      return 2'b00;
  endfunction

endpackage

// File: rtl/pm_state_ctrl.sv
module pm_state_ctrl
  import pm_cap_pkg::*;
#(
  parameter bit D1_SUP = 1'b1,
  parameter bit D2_SUP = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_state,
  output pstate_e    state,
  output logic       req_ok,
  output logic       ev_down,
  output logic       ev_up
);

  move_e mv;
  logic  supp;

  always_comb begin
    supp    = state_supported(req_state, D1_SUP, D2_SUP);
    mv      = classify_move(state, req_state);
    req_ok  = req_valid && supp && (mv != MV_NONE);
    ev_down = req_ok && (mv == MV_DOWN);
    ev_up   = req_ok && (mv == MV_UP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state <= PS_D0;
    else if (req_ok) state <= pstate_e'(req_state);
  end

endmodule

// File: rtl/pm_irq_flags.sv
module pm_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flag,
  output logic [N-1:0] irq
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      f <= 1'b0;
      else if (set[i]) f <= 1'b1;
      else if (clr[i]) f <= 1'b0;
    end
    assign flag[i] = f;
    assign irq[i]  = f & en[i];
  end

endmodule

// File: rtl/pm_cfg_rdmux.sv
module pm_cfg_rdmux
  import pm_cap_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       cap_word,
  input  logic [31:0]       csr_word,
  output logic [31:0]       rdata
);

  localparam logic [ADDR_W-1:0] A_PTR = ADDR_W'(CAPPTR_DW);
  localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(CAP_DW);
  localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(CSR_DW);

  logic [31:0] sel_word;

  always_comb begin
    case (addr)
      A_PTR:   sel_word = {24'h0, PM_CAP_OFFSET};
      A_CAP:   sel_word = cap_word;
      A_CSR:   sel_word = csr_word;
      default: sel_word = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 32'h0;
    else if (rd) rdata <= sel_word;
  end

endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_cap_pkg::*;
#(
  parameter int                    ADDR_W      = 6,
  parameter bit                    D1_SUP      = 1'b1,
  parameter bit                    D2_SUP      = 1'b0,
  parameter bit                    NO_SOFT_RST = 1'b1,
  parameter bit                    DSI         = 1'b0,
  parameter logic [2:0]            AUX_CUR     = 3'd0,
  parameter logic [4:0]            PME_SUP     = 5'd0,
  parameter logic [7:0]            BSE_VAL     = 8'h00,
  parameter logic [8*NUM_DATA-1:0] PWR_DATA    = 64'h0403_0205_0A14_1E32,
  parameter logic [2*NUM_DATA-1:0] PWR_SCALE   = 16'h5555
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              loc_ien_down,
  input  logic              loc_ien_up,
  input  logic              loc_clr_down,
  input  logic              loc_clr_up,
  output logic [1:0]        pwr_state,
  output logic              irq_down,
  output logic              irq_up
);

  localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(CSR_DW);

  logic          csr_hit, st_wr, sel_wr;
  logic [3:0]    dsel;
  pstate_e       state;
  logic          st_ok, ev_down, ev_up;
  logic          flag_down, flag_up;
  logic [NUM_IRQ-1:0] f_set, f_clr, f_en, f_q, f_irq;
  logic [31:0]   cap_word, csr_word;
  logic          unused_wbits;

  assign csr_hit      = cfg_wr && (cfg_addr == A_CSR);
  assign st_wr        = csr_hit && cfg_be[0];
  assign sel_wr       = csr_hit && cfg_be[1];
  assign unused_wbits = ^{cfg_wdata[31:13], cfg_wdata[8:2], cfg_be[3:2], st_ok};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dsel <= 4'd0;
    else if (sel_wr) dsel <= cfg_wdata[12:9];
  end

  pm_state_ctrl #(.D1_SUP(D1_SUP), .D2_SUP(D2_SUP)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (st_wr),
    .req_state (cfg_wdata[1:0]),
    .state     (state),
    .req_ok    (st_ok),
    .ev_down   (ev_down),
    .ev_up     (ev_up)
  );

  assign f_set[IRQ_DOWN] = ev_down;
  assign f_set[IRQ_UP]   = ev_up;
  assign f_clr[IRQ_DOWN] = loc_clr_down;
  assign f_clr[IRQ_UP]   = loc_clr_up;
  assign f_en[IRQ_DOWN]  = loc_ien_down;
  assign f_en[IRQ_UP]    = loc_ien_up;

  pm_irq_flags #(.N(NUM_IRQ)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (f_set),
    .clr   (f_clr),
    .en    (f_en),
    .flag  (f_q),
    .irq   (f_irq)
  );

  assign flag_down = f_q[IRQ_DOWN];
  assign flag_up   = f_q[IRQ_UP];
  assign irq_down  = f_irq[IRQ_DOWN];
  assign irq_up    = f_irq[IRQ_UP];
  assign pwr_state = state;

  assign cap_word = {pack_pmc(PME_SUP, D2_SUP, D1_SUP, AUX_CUR, DSI), PM_NEXT_PTR, PM_CAP_ID};
  assign csr_word = {pick_data(dsel, PWR_DATA), BSE_VAL,
                     pack_csr(pick_scale(dsel, PWR_SCALE), dsel, NO_SOFT_RST, state)};

  pm_cfg_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (cfg_rd),
    .addr     (cfg_addr),
    .cap_word (cap_word),
    .csr_word (csr_word),
    .rdata    (cfg_rdata)
  );

endmodule

// File: rtl/pm_cap_regs_chk.sv
module pm_cap_regs_chk #(
  parameter int ADDR_W = 6,
  parameter bit D2_SUP = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [3:0]        cfg_be,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              loc_ien_down,
  input logic              loc_clr_down,
  input logic [1:0]        pwr_state,
  input logic              irq_down,
  input logic              ev_down,
  input logic              ev_up,
  input logic              flag_down
);

  logic st_write;
  logic mapped;
  assign st_write = cfg_wr && (cfg_addr == ADDR_W'(17)) && cfg_be[0];
  assign mapped   = (cfg_addr == ADDR_W'(13)) || (cfg_addr == ADDR_W'(16)) ||
                    (cfg_addr == ADDR_W'(17));

  // R4: state moves only on a state write
  p_state_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !st_write |=> $stable(pwr_state));

  // R5: unadvertised D2 is refused
  p_unsup_d2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!D2_SUP && st_write && cfg_wdata[1:0] == 2'd2) |=> $stable(pwr_state));

  // R6: at most one event at a time
  p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_down, ev_up}));

  // R6: a down event leaves the flag set
  p_down_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_down |=> flag_down);

  // R7: a restore event only ever targets D0
  p_up_to_d0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_up |=> (pwr_state == 2'd0));

  // R8: flag is sticky without a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_down && !loc_clr_down) |=> flag_down);

  // R8: interrupt needs its enable
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_down |-> loc_ien_down);

  // R10: unmapped reads return zero
  p_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !mapped) |=> (cfg_rdata == 32'h0));

  // R10: read data holds without a read
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata));

endmodule

bind pm_cap_regs pm_cap_regs_chk #(.ADDR_W(ADDR_W), .D2_SUP(D2_SUP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .cfg_rd       (cfg_rd),
  .cfg_addr     (cfg_addr),
  .cfg_be       (cfg_be),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .loc_ien_down (loc_ien_down),
  .loc_clr_down (loc_clr_down),
  .pwr_state    (pwr_state),
  .irq_down     (irq_down),
  .ev_down      (ev_down),
  .ev_up        (ev_up),
  .flag_down    (flag_down)
);

// File: tb/tb_pm_cap_regs.sv
`timescale 1ns/1ps
module tb_pm_cap_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        loc_ien_down = 1'b0, loc_ien_up = 1'b0;
  logic        loc_clr_down = 1'b0, loc_clr_up = 1'b0;
  logic [1:0]  pwr_state;
  logic        irq_down, irq_up;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pm_cap_regs dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .loc_ien_down(loc_ien_down), .loc_ien_up(loc_ien_up),
    .loc_clr_down(loc_clr_down), .loc_clr_up(loc_clr_up),
    .pwr_state(pwr_state), .irq_down(irq_down), .irq_up(irq_up)
  );

  function automatic logic [7:0] exp_data(int sel);
    case (sel)
      0: return 8'h32; 1: return 8'h1E; 2: return 8'h14; 3: return 8'h0A;
      4: return 8'h05; 5: return 8'h02; 6: return 8'h03; 7: return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  // Expected dword 17 built from the R3/R9 field positions
  function automatic logic [31:0] exp_csr(int st, int sel);
    logic [31:0] w;
    w = 32'h0;
    w[1:0]   = st[1:0];
    w[3]     = 1'b1;
    w[12:9]  = sel[3:0];
    w[14:13] = (sel < 8) ? 2'b01 : 2'b00;
    w[31:24] = exp_data(sel);
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic cfg_write(int addr, logic [3:0] be, logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = addr[5:0]; cfg_be = be; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = 32'h0;
  endtask

  task automatic cfg_read(int addr, output logic [31:0] data);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = addr[5:0];
    @(negedge clk);
    cfg_rd = 1'b0;
    data = cfg_rdata;
  endtask

  task automatic clr_down();
    @(negedge clk); loc_clr_down = 1'b1;
    @(negedge clk); loc_clr_down = 1'b0;
  endtask

  task automatic clr_up();
    @(negedge clk); loc_clr_up = 1'b1;
    @(negedge clk); loc_clr_up = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", {30'h0, pwr_state}, 32'd0);
    chk("R1 irqs", {30'h0, irq_down, irq_up}, 32'd0);
    chk("R1 rdata", cfg_rdata, 32'h0);
  endtask

  task automatic t_header();
    logic [31:0] d;
    cfg_read(13, d); chk("R2 cap pointer", d, 32'h0000_0040);
    cfg_read(16, d); chk("R2 cap header", d, 32'h0202_0001);
    cfg_write(16, 4'hF, 32'hFFFF_FFFF);
    cfg_write(13, 4'hF, 32'hFFFF_FFFF);
    cfg_read(16, d); chk("R11 header after write", d, 32'h0202_0001);
    cfg_read(13, d); chk("R11 pointer after write", d, 32'h0000_0040);
    cfg_read(17, d); chk("R3 csr at reset", d, exp_csr(0, 0));
  endtask

  task automatic t_down_sticky();
    loc_ien_down = 1'b1; loc_ien_up = 1'b1;
    cfg_write(17, 4'h1, 32'h1);
    chk("R4 D0->D1 state", {30'h0, pwr_state}, 32'd1);
    chk("R6 down irq", {31'h0, irq_down}, 32'd1);
    chk("R6 no restore irq", {31'h0, irq_up}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 flag sticky", {31'h0, irq_down}, 32'd1);
    loc_ien_down = 1'b0; #1;
    chk("R8 enable masks", {31'h0, irq_down}, 32'd0);
    loc_ien_down = 1'b1; #1;
    chk("R8 flag kept under mask", {31'h0, irq_down}, 32'd1);
    clr_down();
    chk("R8 clear", {31'h0, irq_down}, 32'd0);
  endtask

  task automatic t_ignored();
    cfg_write(17, 4'hE, 32'h3);
    chk("R4 no byte0 enable", {30'h0, pwr_state}, 32'd1);
    chk("R4 no byte0 no irq", {31'h0, irq_down}, 32'd0);
    cfg_write(17, 4'h1, 32'h2);
    chk("R5 unsupported D2", {30'h0, pwr_state}, 32'd1);
    chk("R5 no irq", {31'h0, irq_down}, 32'd0);
    cfg_write(17, 4'h1, 32'h1);
    chk("R6 same state no irq", {30'h0, irq_down, irq_up}, 32'd0);
  endtask

  task automatic t_set_wins_and_back();
    logic [31:0] d;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 6'd17; cfg_be = 4'h1; cfg_wdata = 32'h3;
    loc_clr_down = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = 32'h0; loc_clr_down = 1'b0;
    chk("R6 D1->D3 state", {30'h0, pwr_state}, 32'd3);
    chk("R8 set wins over clear", {31'h0, irq_down}, 32'd1);
    clr_down();
    cfg_write(17, 4'h1, 32'h1);
    chk("R7 D3->D1 ignored", {30'h0, pwr_state}, 32'd3);
    chk("R7 no irq", {30'h0, irq_down, irq_up}, 32'd0);
    cfg_read(17, d); chk("R3 csr in D3", d, exp_csr(3, 0));
    cfg_write(17, 4'h1, 32'h0);
    chk("R6 D3->D0 state", {30'h0, pwr_state}, 32'd0);
    chk("R6 restore irq", {30'h0, irq_down, irq_up}, 32'd1);
    clr_up();
    chk("R8 restore clear", {31'h0, irq_up}, 32'd0);
  endtask

  task automatic t_data();
    logic [31:0] d;
    cfg_write(17, 4'h2, (32'd5 << 9) | 32'h3);
    chk("R4 byte1 only keeps state", {30'h0, pwr_state}, 32'd0);
    cfg_read(17, d); chk("R9 select 5", d, exp_csr(0, 5));
    cfg_write(17, 4'h2, 32'd7 << 9);
    cfg_read(17, d); chk("R9 select 7", d, exp_csr(0, 7));
    cfg_write(17, 4'h2, 32'd9 << 9);
    cfg_read(17, d); chk("R9 select 9 reads zero", d, exp_csr(0, 9));
  endtask

  task automatic t_read_path();
    logic [31:0] d;
    cfg_read(34, d); chk("R10 unmapped", d, 32'h0);
    cfg_read(16, d); chk("R10 read latency", d, 32'h0202_0001);
    @(negedge clk); @(negedge clk);
    chk("R10 rdata holds", cfg_rdata, 32'h0202_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_header();
    t_down_sticky();
    t_ignored();
    t_set_wins_and_back();
    t_data();
    t_read_path();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule